// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Cycle Controller

This block is a synthesizable model of a pipelined synchronous burst static RAM with a 64-bit word split into eight byte lanes. On each rising clock edge it looks at three chip enables, a processor address strobe, a chipset address strobe and an advance strobe. From these it picks one cycle type: deselect, start of a read, start of a write, advance to the next burst address, or hold at the current one. A two-bit burst counter steps through four word addresses, in either a linear or an interleaved order that a static input selects.

Read data goes through an output register. The word at a registered address appears one clock after that address or advance is taken. An asynchronous output enable gates the data drive. Write data and its byte-lane qualifiers are captured one clock after the address that they belong to. A global write forces all eight lanes; otherwise a byte-write enable qualifies the per-lane enables. A sleep input freezes the model. Contents and burst state are kept, and the data drive is off until sleep is released.

Top module: `sbsram_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first read, `dq_oe` is low.
- R2: A cycle with `adsp_n` low, `ce1_n` low, `ce2` high and `ce3_n` low starts a read at `addr`, whatever the write controls are. The word at that address is on `dq_o` with `dq_oe` high after the following clock edge.
- R3: A cycle with `adsp_n` high, `adsc_n` low and all three enables active starts a write at `addr` if a write control is active (`gw_n` low, or `bwe_n` low with at least one `bw_n` bit low). Otherwise it starts a read. The data and lane controls of a write are taken from the next clock edge, and `dq_oe` stays low during the write.
- R4: Lane i is bits [8i+7:8i]. With `gw_n` low, all lanes are written. With `gw_n` high and `bwe_n` low, lane i is written only where `bw_n[i]` is low. With both high, nothing is written.
- R5: With both strobes high and `adv_n` low, the burst advances. The low two address bits become start+n mod 4 when `burst_linear` is 1, and start XOR n when it is 0. The upper bits stay fixed.
- R6: With both strobes high and `adv_n` high, the address is held, so a read repeats the same word.
- R7: `adsp_n` low with `ce1_n` low, while `ce2` is low or `ce3_n` is high, deselects the part. `dq_oe` is low after that edge.
- R8: `adsc_n` low with `ce1_n` high deselects the part. `adsp_n` low with `ce1_n` high is ignored, and the cycle is decoded from `adsc_n` and `adv_n` alone.
- R9: `oe_n` high forces `dq_oe` low at once, without waiting for a clock edge.
- R10: While `sleep` is high, every other input is ignored, the contents and burst state are kept, and `dq_oe` is low. After wake-up the burst resumes where it stopped.
- R11: A deselect through `ce2` or `ce3_n` during a read burst turns `dq_oe` off after that same edge. The word pending for that edge is not presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Retention request, active high |
| ce1_n | input | 1 | Chip enable 1, active low; when high it blocks the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Chipset address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Data drive enable; low stands for high impedance |

## Verification
The bench targets the corner cases where a wrong design gives a visibly different word or drive. A design that honours the processor strobe while `ce1_n` is high would restart the burst, and the next word would repeat the start address. A design that ignores the order select would return 5,6,7,4 instead of 5,4,7,6 for an interleaved burst. Latching the byte lanes with the address instead of with the data would corrupt the partial-write word. Keeping the drive on for one more cycle after a `ce2` or `ce3_n` deselect would leak a fifth word. A design that still decodes strobes during sleep would overwrite a stored word, or would lose its place in the burst.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [2:0] {
    CYC_DESEL    = 3'd0,
    CYC_RD_START = 3'd1,
    CYC_WR_START = 3'd2,
    CYC_ADVANCE  = 3'd3,
    CYC_HOLD     = 3'd4
  } cyc_kind_e;

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output cyc_kind_e        kind,
  output logic [LANES-1:0] lanes
);

  logic sel_all;
  logic wr_req;

  always_comb begin
    if (!gw_n)       lanes = '1;
    else if (!bwe_n) lanes = ~bw_n;
    else             lanes = '0;
  end

  assign wr_req  = |lanes;
  assign sel_all = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (!adsp_n && !ce1_n) begin
      kind = sel_all ? CYC_RD_START : CYC_DESEL;
    end else if (!adsc_n) begin
      if (!sel_all)    kind = CYC_DESEL;
      else if (wr_req) kind = CYC_WR_START;
      else             kind = CYC_RD_START;
    end else begin
      kind = adv_n ? CYC_HOLD : CYC_ADVANCE;
    end
  end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  low_bits;

  always_comb begin
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      base_d = addr_in;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign low_bits = linear ? (base_q[CNT_W-1:0] + cnt_q)
                           : (base_q[CNT_W-1:0] ^ cnt_q);
  assign addr_o   = {base_q[ADDR_W-1:CNT_W], low_bits};

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we_lanes,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lanes[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];
  end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    burst_linear,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  cyc_kind_e         kind;
  logic [LANES-1:0]  lanes;
  logic [LANES-1:0]  we_lanes;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] rdata;
  logic              clk_en;
  logic              load, step;
  logic              wr_commit, rd_fire;

  logic              active_q, active_d;
  logic              wr_q, wr_d;
  logic              drv_q, drv_d;
  logic [DATA_W-1:0] out_q, out_d;

  sbsram_decode #(.LANES(LANES)) u_decode (
    .ce1_n  (ce1_n),
    .ce2    (ce2),
    .ce3_n  (ce3_n),
    .adsp_n (adsp_n),
    .adsc_n (adsc_n),
    .adv_n  (adv_n),
    .gw_n   (gw_n),
    .bwe_n  (bwe_n),
    .bw_n   (bw_n),
    .kind   (kind),
    .lanes  (lanes)
  );

  assign clk_en = !sleep;
  assign load   = (kind == CYC_RD_START) || (kind == CYC_WR_START);
  assign step   = (kind == CYC_ADVANCE) && active_q;

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (clk_en),
    .load    (load),
    .step    (step),
    .linear  (burst_linear),
    .addr_in (addr),
    .addr_o  (cur_addr)
  );

  // write beat: data and lane controls belong to the address taken one edge earlier
  assign wr_commit = clk_en && active_q && wr_q;
  assign we_lanes  = wr_commit ? lanes : '0;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .we_lanes (we_lanes),
    .addr     (cur_addr),
    .wdata    (din),
    .rdata    (rdata)
  );

  // read beat: a deselect on this edge suppresses the pending word
  assign rd_fire = active_q && !wr_q && (kind != CYC_DESEL);

  always_comb begin
    active_d = active_q;
    wr_d     = wr_q;
    unique case (kind)
      CYC_DESEL:    active_d = 1'b0;
      CYC_RD_START: begin active_d = 1'b1; wr_d = 1'b0; end
      CYC_WR_START: begin active_d = 1'b1; wr_d = 1'b1; end
      default:      ;
    endcase
    drv_d = rd_fire;
    out_d = rd_fire ? rdata : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      drv_q    <= 1'b0;
      out_q    <= '0;
    end else if (clk_en) begin
      active_q <= active_d;
      wr_q     <= wr_d;
      drv_q    <= drv_d;
      out_q    <= out_d;
    end
  end

  assign dq_o  = out_q;
  assign dq_oe = drv_q && !oe_n && !sleep;

endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              gw_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe
);

  always_comb begin
    if (!rst_n) assert_quiet_in_reset_R1: assert (!dq_oe);
  end

  assert_oe_gates_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  assert_sleep_no_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);

  assert_sleep_freezes_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dq_o));

  assert_bad_enable_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsp_n && !ce1_n && (!ce2 || ce3_n)) |=> !dq_oe);

  assert_chipset_desel_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !adsc_n && ce1_n) |=> !dq_oe);

  assert_write_start_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && adsp_n && !adsc_n && !ce1_n && ce2 && !ce3_n && !gw_n) |=> !dq_oe);

endmodule

bind sbsram_ctrl sbsram_ctrl_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sleep  (sleep),
  .ce1_n  (ce1_n),
  .ce2    (ce2),
  .ce3_n  (ce3_n),
  .adsp_n (adsp_n),
  .adsc_n (adsc_n),
  .gw_n   (gw_n),
  .oe_n   (oe_n),
  .dq_o   (dq_o),
  .dq_oe  (dq_oe)
);

// File: tb/tb_sbsram_ctrl.sv
module tb_sbsram_ctrl;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int DW     = LANES * LANE_W;

  logic clk, rst_n, sleep, ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n;
  logic gw_n, bwe_n, burst_linear, oe_n, dq_oe;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  bw_n;
  logic [DW-1:0]     din, dq_o;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  bit          exp_chk_q [$];
  bit          exp_oe_q  [$];
  logic [DW-1:0] exp_d_q [$];
  string       tag_q     [$];

  sbsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .burst_linear(burst_linear), .oe_n(oe_n), .din(din),
    .dq_o(dq_o), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a);
    return {8{8'(a * 7 + 3)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic report(input string tag, input bit ok,
                        input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rest();
    sleep = 0; ce1_n = 0; ce2 = 1; ce3_n = 0;
    adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 0; din = '0;
  endtask

  // driver: push the expected output after the coming edge, then clock it
  task automatic tick(input bit chk, input bit oe, input logic [DW-1:0] d,
                      input string tag);
    exp_chk_q.push_back(chk);
    exp_oe_q.push_back(oe);
    exp_d_q.push_back(d);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: compare a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (tag_q.size() > 0) begin
        automatic bit          c = exp_chk_q.pop_front();
        automatic bit          o = exp_oe_q.pop_front();
        automatic logic [DW-1:0] d = exp_d_q.pop_front();
        automatic string       t = tag_q.pop_front();
        if (c) begin
          if (o) report(t, (dq_oe === 1'b1) && (dq_o === d), {dq_oe, dq_o}, {1'b1, d});
          else   report(t, dq_oe === 1'b0, {dq_oe, dq_o}, {1'b0, d});
        end
      end
    end
  end

  initial begin
    #(CLK_P * 2000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp8;
    rst_n = 0; rest(); addr = '0; burst_linear = 1;
    repeat (3) @(negedge clk);
    report("R1", dq_oe === 1'b0, {dq_oe, dq_o}, '0);
    rst_n = 1;
    tick(1, 0, '0, "R1");

    // fill words 0..7 with linear write bursts; last beat also deselects (R3, R8)
    for (int b = 0; b < 8; b += 4) begin
      rest(); adsc_n = 0; gw_n = 0; addr = ADDR_W'(b);
      tick(1, 0, '0, "R3");
      for (int i = 0; i < 3; i++) begin
        rest(); adv_n = 0; gw_n = 0; din = pat(b + i);
        tick(1, 0, '0, "R3");
      end
      rest(); adsc_n = 0; ce1_n = 1; gw_n = 0; din = pat(b + 3);
      tick(1, 0, '0, "R8");
    end

    // partial lane write at word 8: full write, lanes 1 and 3, then a no-write beat (R4)
    rest(); adsc_n = 0; gw_n = 0; addr = 6'd8;
    tick(1, 0, '0, "R3");
    rest(); gw_n = 0; din = pat(8);
    tick(1, 0, '0, "R4");
    rest(); bwe_n = 0; bw_n = 8'b1111_0101; din = '1;
    tick(1, 0, '0, "R4");
    rest(); adsc_n = 0; ce1_n = 1; din = '0;
    tick(1, 0, '0, "R4");
    exp8 = pat(8); exp8[15:8] = 8'hFF; exp8[31:24] = 8'hFF;
    rest(); adsc_n = 0; addr = 6'd8;          // no write control: read start (R3)
    tick(1, 0, '0, "R3");
    rest();
    tick(1, 1, exp8, "R4");
    rest(); adsc_n = 0; ce1_n = 1;
    tick(1, 0, '0, "R8");

    // linear read burst from word 1 started by ADSP with write controls active (R2)
    rest(); adsp_n = 0; gw_n = 0; addr = 6'd1;
    tick(1, 0, '0, "R2");
    rest(); adv_n = 0;
    tick(1, 1, pat(1), "R2");
    rest(); adv_n = 0; adsp_n = 0; ce1_n = 1;  // ADSP blocked by CE1 (R8)
    tick(1, 1, pat(2), "R8");
    rest(); adv_n = 0; oe_n = 1;
    tick(1, 0, '0, "R9");
    rest();
    tick(1, 1, pat(0), "R5");                  // wrapped 1,2,3,0
    rest();
    tick(1, 1, pat(0), "R6");
    rest(); adsp_n = 0; ce2 = 0;
    tick(1, 0, '0, "R11");

    // interleaved read from word 5: 5,4,7,6 (R5)
    burst_linear = 0;
    rest(); adsp_n = 0; addr = 6'd5;
    tick(1, 0, '0, "R2");
    rest(); adv_n = 0; tick(1, 1, pat(5), "R5");
    rest(); adv_n = 0; tick(1, 1, pat(4), "R5");
    rest(); adv_n = 0; tick(1, 1, pat(7), "R5");
    rest(); adv_n = 0; tick(1, 1, pat(6), "R5");
    rest(); adsp_n = 0; ce3_n = 1;
    tick(1, 0, '0, "R7");
    rest(); tick(1, 0, '0, "R11");
    burst_linear = 1;

    // sleep in mid burst with write traffic on the pins (R10)
    rest(); adsp_n = 0; addr = 6'd4;
    tick(1, 0, '0, "R2");
    rest(); adv_n = 0;
    tick(1, 1, pat(4), "R2");
    for (int k = 0; k < 3; k++) begin
      rest(); sleep = 1; adsc_n = 0; gw_n = 0; addr = 6'd4; din = '1; adv_n = 0;
      tick(1, 0, '0, "R10");
    end
    rest();
    tick(1, 1, pat(5), "R10");
    rest(); adv_n = 0;
    tick(1, 1, pat(5), "R10");
    rest(); adv_n = 0;
    tick(1, 1, pat(6), "R10");
    rest(); adsc_n = 0; ce1_n = 1;
    tick(1, 0, '0, "R8");
    rest(); adsp_n = 0; addr = 6'd4;
    tick(1, 0, '0, "R2");
    rest();
    tick(1, 1, pat(4), "R10");
    rest(); adsp_n = 0; ce2 = 0;
    tick(1, 0, '0, "R7");

    rest();
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule